// File: doc/BRIEF.md
# Protected Key Store Controller

This block holds cipher keys in a private memory of eight 128-bit entries and exposes them only in two directions: in, from a DMA write stream, and out, straight to the cipher's key registers over a dedicated port. Software chooses where an incoming key lands by writing a one-hot area selection. The next DMA transfer then fills that entry with four 32-bit beats, least significant word first. When the DMA signals the end of the transfer, the block either marks the entry as holding a valid key or records a write error.

A bitmap of valid entries tells software which slots are occupied. An occupied slot refuses new key data until software frees it by writing 1 to its bit. A load request names an entry. If the entry is valid, the block streams its four words to the cipher and then pulses a completion strobe. If it is not valid, the block raises a load error and sends nothing. The error flags stay set until software clears them with write-1-to-clear. No register output carries key material. The key port drives zero whenever it is not streaming.

Top module: `key_store_ctrl`

## Requirements
- R1: After reset the valid bitmap, the area selection, both error flags, `key_valid_o`, `key_word_o` and `ld_done_o` are all zero.
- R2: After a one-hot area selection, exactly four beats into a free entry followed by `dma_done_i` set that entry's bit in `valid_map_o` (bit i = entry i). The bit is visible in the cycle after the `dma_done_i` cycle, and no error is raised.
- R3: Fewer than four beats before `dma_done_i` raise the write error, `err_status_o[0]`, in the cycle after `dma_done_i` and not earlier. The valid bitmap is left unchanged.
- R4: A write outside the selected area raises `err_status_o[0]` at `dma_done_i` and leaves the valid bitmap unchanged. This covers a fifth or later beat, beats while no area is armed, and beats after a selection that is not one-hot. A selection that is not one-hot reads back as zero, and the selection register is always zero or one-hot.
- R5: Key beats aimed at an entry whose valid bit is set are discarded and raise `err_status_o[0]` at `dma_done_i`. The stored key stays intact.
- R6: Writing `vclr_we_i` with mask bit i = 1 clears valid bit i in the following cycle. Mask bits that are 0 leave their entries untouched.
- R7: A load request accepted on a valid entry drives `key_valid_o` for four consecutive cycles, starting the cycle after the request, carrying word 0 (bits 31:0) up to word 3. `ld_done_o` pulses for one cycle right after the last word.
- R8: A load request on an invalid entry emits no word and no `ld_done_o`. It sets the load error, `err_status_o[1]`, in the next cycle.
- R9: Error flags are sticky. Writing 1 to bit k of `err_clr_i` clears only flag k. If a flag is set and cleared in the same cycle, the set wins.
- R10: `key_word_o` is zero in every cycle in which `key_valid_o` is low.
- R11: A load request that arrives while a load is in progress is ignored. The running transfer completes unchanged and no second transfer follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| area_we_i | input | 1 | Write strobe for the area selection register |
| area_wdata_i | input | 8 | One-hot entry selection for the next DMA key transfer |
| vclr_we_i | input | 1 | Write strobe for the valid bitmap (write-1-to-clear) |
| vclr_mask_i | input | 8 | Entries whose valid bit is to be cleared |
| err_clr_i | input | 2 | Write-1-to-clear for the error flags |
| dma_valid_i | input | 1 | DMA key beat present |
| dma_data_i | input | 32 | DMA key beat data |
| dma_done_i | input | 1 | End-of-transfer pulse from the DMA |
| ld_req_i | input | 1 | Key load request |
| ld_idx_i | input | 3 | Entry to load |
| area_sel_o | output | 8 | Read-back of the area selection |
| valid_map_o | output | 8 | Bitmap of entries holding a valid key |
| err_status_o | output | 2 | Bit 0 write error, bit 1 load error |
| ld_busy_o | output | 1 | A load is in progress |
| key_valid_o | output | 1 | A key word is present on the private port |
| key_word_o | output | 32 | Key word to the cipher key registers |
| ld_done_o | output | 1 | One-cycle pulse after the last key word |

## Verification
Register-side results (valid bits, error flags, area read-back) are due one clock edge after the strobe or `dma_done_i` that causes them. Key words are due one edge after an accepted request and then one per edge, with `ld_done_o` on the fifth edge. The bench drives every input on the falling edge and samples on the next falling edge after each rising edge. Each check therefore lands exactly in the cycle the requirement names. The write error is also sampled before `dma_done_i`, which shows it is not raised early. Every entry is written and loaded back with an arithmetic pattern, and each error path is driven against known occupied and free slots.

// File: rtl/ks_pkg.sv
package ks_pkg;

   typedef enum logic [1:0] {
      LD_IDLE = 2'd0,
      LD_XFER = 2'd1,
      LD_DONE = 2'd2
   } ld_state_e;

   localparam int ERR_W      = 2;
   localparam int ERR_WR_BIT = 0;
   localparam int ERR_LD_BIT = 1;

endpackage

// File: rtl/ks_mem.sv
module ks_mem #(
   parameter int NUM_ENTRIES   = 8,
   parameter int WORD_W        = 32,
   parameter int WORDS_PER_KEY = 4,
   localparam int IDX_W        = $clog2(NUM_ENTRIES),
   localparam int BEAT_W       = $clog2(WORDS_PER_KEY)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en_i,
   input  logic [IDX_W-1:0]  wr_entry_i,
   input  logic [BEAT_W-1:0] wr_beat_i,
   input  logic [WORD_W-1:0] wr_data_i,
   input  logic [IDX_W-1:0]  rd_entry_i,
   input  logic [BEAT_W-1:0] rd_beat_i,
   output logic [WORD_W-1:0] rd_data_o
);

   localparam int DEPTH = NUM_ENTRIES * WORDS_PER_KEY;

   logic [WORD_W-1:0] word_q [DEPTH];

   for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_entry
      for (genvar b = 0; b < WORDS_PER_KEY; b++) begin : g_word
         logic hit;
         assign hit = wr_en_i
                   && (wr_entry_i == IDX_W'(e))
                   && (wr_beat_i  == BEAT_W'(b));
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               word_q[e*WORDS_PER_KEY + b] <= '0;
            end else if (hit) begin
               word_q[e*WORDS_PER_KEY + b] <= wr_data_i;
            end
         end
      end
   end

   always_comb begin
      rd_data_o = '0;
      for (int e = 0; e < NUM_ENTRIES; e++) begin
         for (int b = 0; b < WORDS_PER_KEY; b++) begin
            if (rd_entry_i == IDX_W'(e) && rd_beat_i == BEAT_W'(b)) begin
               rd_data_o = word_q[e*WORDS_PER_KEY + b];
            end
         end
      end
   end

endmodule

// File: rtl/ks_write_ctrl.sv
module ks_write_ctrl #(
   parameter int NUM_ENTRIES   = 8,
   parameter int WORD_W        = 32,
   parameter int WORDS_PER_KEY = 4,
   localparam int IDX_W        = $clog2(NUM_ENTRIES),
   localparam int BEAT_W       = $clog2(WORDS_PER_KEY),
   localparam int CNT_W        = $clog2(WORDS_PER_KEY + 1)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   area_we_i,
   input  logic [NUM_ENTRIES-1:0] area_wdata_i,
   input  logic                   vclr_we_i,
   input  logic [NUM_ENTRIES-1:0] vclr_mask_i,
   input  logic                   dma_valid_i,
   input  logic [WORD_W-1:0]      dma_data_i,
   input  logic                   dma_done_i,
   output logic [NUM_ENTRIES-1:0] area_sel_o,
   output logic [NUM_ENTRIES-1:0] valid_map_o,
   output logic                   wr_err_evt_o,
   output logic                   mem_wr_en_o,
   output logic [IDX_W-1:0]       mem_wr_entry_o,
   output logic [BEAT_W-1:0]      mem_wr_beat_o,
   output logic [WORD_W-1:0]      mem_wr_data_o
);

   localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORDS_PER_KEY);

   logic [NUM_ENTRIES-1:0] area_q;
   logic [NUM_ENTRIES-1:0] valid_q;
   logic                   armed_q;
   logic                   fault_q;
   logic [CNT_W-1:0]       cnt_q;

   logic [IDX_W-1:0]       area_idx;
   logic                   sel_ok;
   logic                   beat_ok;
   logic                   beat_bad;
   logic [CNT_W-1:0]       cnt_nxt;
   logic                   fault_nxt;
   logic                   done_ok;
   logic [NUM_ENTRIES-1:0] set_mask;
   logic [NUM_ENTRIES-1:0] clr_mask;

   always_comb begin
      area_idx = '0;
      for (int i = 0; i < NUM_ENTRIES; i++) begin
         if (area_q[i]) area_idx = IDX_W'(i);
      end
   end

   assign sel_ok    = $onehot(area_wdata_i);
   assign beat_ok   = dma_valid_i && armed_q && (cnt_q < CNT_FULL)
                   && !valid_q[area_idx];
   assign beat_bad  = dma_valid_i && !beat_ok;
   assign cnt_nxt   = cnt_q + CNT_W'(beat_ok);
   assign fault_nxt = fault_q || beat_bad;
   assign done_ok   = dma_done_i && armed_q && !fault_nxt && (cnt_nxt == CNT_FULL);
   assign set_mask  = done_ok ? area_q : '0;
   assign clr_mask  = vclr_we_i ? vclr_mask_i : '0;

   assign wr_err_evt_o = dma_done_i && !done_ok && (armed_q || fault_nxt);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         area_q  <= '0;
         armed_q <= 1'b0;
         fault_q <= 1'b0;
         cnt_q   <= '0;
      end else if (area_we_i) begin
         area_q  <= sel_ok ? area_wdata_i : '0;
         armed_q <= sel_ok;
         fault_q <= 1'b0;
         cnt_q   <= '0;
      end else if (dma_done_i) begin
         armed_q <= 1'b0;
         fault_q <= 1'b0;
         cnt_q   <= '0;
      end else begin
         fault_q <= fault_nxt;
         cnt_q   <= cnt_nxt;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= '0;
      end else begin
         valid_q <= (valid_q | set_mask) & ~clr_mask;
      end
   end

   assign area_sel_o     = area_q;
   assign valid_map_o    = valid_q;
   assign mem_wr_en_o    = beat_ok;
   assign mem_wr_entry_o = area_idx;
   assign mem_wr_beat_o  = cnt_q[BEAT_W-1:0];
   assign mem_wr_data_o  = dma_data_i;

endmodule

// File: rtl/ks_load_ctrl.sv
module ks_load_ctrl
   import ks_pkg::*;
#(
   parameter int NUM_ENTRIES   = 8,
   parameter int WORDS_PER_KEY = 4,
   localparam int IDX_W        = $clog2(NUM_ENTRIES),
   localparam int BEAT_W       = $clog2(WORDS_PER_KEY)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   ld_req_i,
   input  logic [IDX_W-1:0]       ld_idx_i,
   input  logic [NUM_ENTRIES-1:0] valid_map_i,
   output logic [IDX_W-1:0]       rd_entry_o,
   output logic [BEAT_W-1:0]      rd_beat_o,
   output logic                   xfer_o,
   output logic                   done_o,
   output logic                   busy_o,
   output logic                   ld_err_evt_o
);

   localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(WORDS_PER_KEY - 1);

   ld_state_e         state_q;
   logic [IDX_W-1:0]  idx_q;
   logic [BEAT_W-1:0] beat_q;
   logic              take;
   logic              hit;

   assign take = ld_req_i && (state_q == LD_IDLE);
   assign hit  = (int'(ld_idx_i) < NUM_ENTRIES) && valid_map_i[ld_idx_i];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= LD_IDLE;
         idx_q   <= '0;
         beat_q  <= '0;
      end else begin
         unique case (state_q)
            LD_IDLE: begin
               if (take && hit) begin
                  state_q <= LD_XFER;
                  idx_q   <= ld_idx_i;
                  beat_q  <= '0;
               end
            end
            LD_XFER: begin
               beat_q <= beat_q + 1'b1;
               if (beat_q == LAST_BEAT) state_q <= LD_DONE;
            end
            default: state_q <= LD_IDLE;
         endcase
      end
   end

   assign rd_entry_o   = idx_q;
   assign rd_beat_o    = beat_q;
   assign xfer_o       = (state_q == LD_XFER);
   assign done_o       = (state_q == LD_DONE);
   assign busy_o       = (state_q != LD_IDLE);
   assign ld_err_evt_o = take && !hit;

endmodule

// File: rtl/key_store_ctrl.sv
module key_store_ctrl
   import ks_pkg::*;
#(
   parameter int NUM_ENTRIES   = 8,
   parameter int WORD_W        = 32,
   parameter int WORDS_PER_KEY = 4,
   localparam int IDX_W        = $clog2(NUM_ENTRIES),
   localparam int BEAT_W       = $clog2(WORDS_PER_KEY)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   area_we_i,
   input  logic [NUM_ENTRIES-1:0] area_wdata_i,
   input  logic                   vclr_we_i,
   input  logic [NUM_ENTRIES-1:0] vclr_mask_i,
   input  logic [ERR_W-1:0]       err_clr_i,
   input  logic                   dma_valid_i,
   input  logic [WORD_W-1:0]      dma_data_i,
   input  logic                   dma_done_i,
   input  logic                   ld_req_i,
   input  logic [IDX_W-1:0]       ld_idx_i,
   output logic [NUM_ENTRIES-1:0] area_sel_o,
   output logic [NUM_ENTRIES-1:0] valid_map_o,
   output logic [ERR_W-1:0]       err_status_o,
   output logic                   ld_busy_o,
   output logic                   key_valid_o,
   output logic [WORD_W-1:0]      key_word_o,
   output logic                   ld_done_o
);

   if (NUM_ENTRIES < 2) begin : g_bad_entries
      $error("key_store_ctrl: NUM_ENTRIES must be at least 2");
   end
   if (WORDS_PER_KEY < 2) begin : g_bad_words
      $error("key_store_ctrl: WORDS_PER_KEY must be at least 2");
   end
   if (WORD_W < 8) begin : g_bad_width
      $error("key_store_ctrl: WORD_W must be at least 8");
   end

   logic              mem_wr_en;
   logic [IDX_W-1:0]  mem_wr_entry;
   logic [BEAT_W-1:0] mem_wr_beat;
   logic [WORD_W-1:0] mem_wr_data;
   logic [IDX_W-1:0]  rd_entry;
   logic [BEAT_W-1:0] rd_beat;
   logic [WORD_W-1:0] rd_data;
   logic              wr_err_evt;
   logic              ld_err_evt;
   logic              xfer;
   logic [ERR_W-1:0]  err_q;
   logic [ERR_W-1:0]  err_set;

   ks_write_ctrl #(
      .NUM_ENTRIES   (NUM_ENTRIES),
      .WORD_W        (WORD_W),
      .WORDS_PER_KEY (WORDS_PER_KEY)
   ) i_wr (
      .clk            (clk),
      .rst_n          (rst_n),
      .area_we_i      (area_we_i),
      .area_wdata_i   (area_wdata_i),
      .vclr_we_i      (vclr_we_i),
      .vclr_mask_i    (vclr_mask_i),
      .dma_valid_i    (dma_valid_i),
      .dma_data_i     (dma_data_i),
      .dma_done_i     (dma_done_i),
      .area_sel_o     (area_sel_o),
      .valid_map_o    (valid_map_o),
      .wr_err_evt_o   (wr_err_evt),
      .mem_wr_en_o    (mem_wr_en),
      .mem_wr_entry_o (mem_wr_entry),
      .mem_wr_beat_o  (mem_wr_beat),
      .mem_wr_data_o  (mem_wr_data)
   );

   ks_mem #(
      .NUM_ENTRIES   (NUM_ENTRIES),
      .WORD_W        (WORD_W),
      .WORDS_PER_KEY (WORDS_PER_KEY)
   ) i_mem (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en_i    (mem_wr_en),
      .wr_entry_i (mem_wr_entry),
      .wr_beat_i  (mem_wr_beat),
      .wr_data_i  (mem_wr_data),
      .rd_entry_i (rd_entry),
      .rd_beat_i  (rd_beat),
      .rd_data_o  (rd_data)
   );

   ks_load_ctrl #(
      .NUM_ENTRIES   (NUM_ENTRIES),
      .WORDS_PER_KEY (WORDS_PER_KEY)
   ) i_ld (
      .clk          (clk),
      .rst_n        (rst_n),
      .ld_req_i     (ld_req_i),
      .ld_idx_i     (ld_idx_i),
      .valid_map_i  (valid_map_o),
      .rd_entry_o   (rd_entry),
      .rd_beat_o    (rd_beat),
      .xfer_o       (xfer),
      .done_o       (ld_done_o),
      .busy_o       (ld_busy_o),
      .ld_err_evt_o (ld_err_evt)
   );

   always_comb begin
      err_set             = '0;
      err_set[ERR_WR_BIT] = wr_err_evt;
      err_set[ERR_LD_BIT] = ld_err_evt;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         err_q <= '0;
      end else begin
         err_q <= (err_q & ~err_clr_i) | err_set;
      end
   end

   assign err_status_o = err_q;
   assign key_valid_o  = xfer;
   assign key_word_o   = xfer ? rd_data : '0;

endmodule

// File: rtl/ks_chk.sv
module ks_chk #(
   parameter int NUM_ENTRIES = 8,
   parameter int WORD_W      = 32,
   localparam int IDX_W      = $clog2(NUM_ENTRIES)
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   dma_done_i,
   input logic                   ld_req_i,
   input logic [NUM_ENTRIES-1:0] area_sel_o,
   input logic [NUM_ENTRIES-1:0] valid_map_o,
   input logic [1:0]             err_status_o,
   input logic                   ld_busy_o,
   input logic                   key_valid_o,
   input logic                   ld_done_o
);

   // R2
   valid_set_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((valid_map_o & ~$past(valid_map_o)) != '0) |-> $past(dma_done_i));

   // R3
   wr_err_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err_status_o[0]) |-> $past(dma_done_i));

   // R4
   area_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(area_sel_o));

   // R7
   done_after_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ld_done_o |-> ($past(key_valid_o) && !key_valid_o));

   // R7
   word_needs_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(key_valid_o) |-> ($past(ld_req_i) && !$past(ld_busy_o)));

   // R8
   ld_err_needs_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err_status_o[1]) |-> $past(ld_req_i));

endmodule

bind key_store_ctrl ks_chk #(
   .NUM_ENTRIES (NUM_ENTRIES),
   .WORD_W      (WORD_W)
) i_ks_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .dma_done_i   (dma_done_i),
   .ld_req_i     (ld_req_i),
   .area_sel_o   (area_sel_o),
   .valid_map_o  (valid_map_o),
   .err_status_o (err_status_o),
   .ld_busy_o    (ld_busy_o),
   .key_valid_o  (key_valid_o),
   .ld_done_o    (ld_done_o)
);

// File: tb/test_key_store_ctrl.sv
`timescale 1ns/1ps
module test_key_store_ctrl;

   localparam int N = 8;
   localparam int W = 32;
   localparam int K = 4;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         area_we = 1'b0;
   logic [N-1:0] area_wdata = '0;
   logic         vclr_we = 1'b0;
   logic [N-1:0] vclr_mask = '0;
   logic [1:0]   err_clr = '0;
   logic         dma_valid = 1'b0;
   logic [W-1:0] dma_data = '0;
   logic         dma_done = 1'b0;
   logic         ld_req = 1'b0;
   logic [2:0]   ld_idx = '0;
   logic [N-1:0] area_sel;
   logic [N-1:0] valid_map;
   logic [1:0]   err_status;
   logic         ld_busy;
   logic         key_valid;
   logic [W-1:0] key_word;
   logic         ld_done;

   int checks = 0;
   int failures = 0;
   bit finished = 1'b0;
   logic [N-1:0] exp_valid = '0;

   always #10 clk = ~clk;

   key_store_ctrl i_key_store_ctrl (
      .clk (clk), .rst_n (rst_n),
      .area_we_i (area_we), .area_wdata_i (area_wdata),
      .vclr_we_i (vclr_we), .vclr_mask_i (vclr_mask),
      .err_clr_i (err_clr),
      .dma_valid_i (dma_valid), .dma_data_i (dma_data), .dma_done_i (dma_done),
      .ld_req_i (ld_req), .ld_idx_i (ld_idx),
      .area_sel_o (area_sel), .valid_map_o (valid_map),
      .err_status_o (err_status), .ld_busy_o (ld_busy),
      .key_valid_o (key_valid), .key_word_o (key_word), .ld_done_o (ld_done)
   );

   function automatic logic [W-1:0] kw(int e, int b, int salt);
      return {8'(salt), 8'(e * 17), 8'(b + 1), 8'h5A};
   endfunction

   task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic set_area(logic [N-1:0] v);
      area_we = 1'b1; area_wdata = v; tick();
      area_we = 1'b0; area_wdata = '0;
   endtask

   task automatic beat(logic [W-1:0] d);
      dma_valid = 1'b1; dma_data = d; tick();
      dma_valid = 1'b0; dma_data = '0;
   endtask

   task automatic finish_dma();
      dma_done = 1'b1; tick();
      dma_done = 1'b0;
   endtask

   task automatic clr_err(logic [1:0] m);
      err_clr = m; tick();
      err_clr = '0;
   endtask

   task automatic write_key(int e, int salt);
      set_area(N'(1) << e);
      for (int b = 0; b < K; b++) beat(kw(e, b, salt));
      finish_dma();
   endtask

   // requests entry e and checks the four words and the done pulse (R7, R10)
   task automatic load_check(int e, int salt, string req);
      ld_req = 1'b1; ld_idx = 3'(e); tick();
      ld_req = 1'b0;
      for (int b = 0; b < K; b++) begin
         chk({req, " word valid"}, 64'(key_valid), 64'd1);
         chk({req, " word"}, 64'(key_word), 64'(kw(e, b, salt)));
         if (b < K - 1) tick();
      end
      tick();
      chk({req, " R7 done"}, 64'({ld_done, key_valid}), 64'b10);
      chk("R10 idle word", 64'(key_word), 64'd0);
      tick();
      chk("R7 done one cycle", 64'(ld_done), 64'd0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         failures++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (3) tick();
      // R1 reset state
      chk("R1 valid", 64'(valid_map), 64'd0);
      chk("R1 area", 64'(area_sel), 64'd0);
      chk("R1 err", 64'(err_status), 64'd0);
      chk("R1 key port", 64'({key_valid, key_word, ld_done}), 64'd0);
      rst_n = 1'b1;
      tick();

      // R2 fill every entry
      for (int e = 0; e < N; e++) begin
         set_area(N'(1) << e);
         chk("R2 area readback", 64'(area_sel), 64'(N'(1) << e));
         for (int b = 0; b < K; b++) beat(kw(e, b, 1));
         chk("R2 not valid before done", 64'(valid_map), 64'(exp_valid));
         finish_dma();
         exp_valid[e] = 1'b1;
         chk("R2 valid after done", 64'(valid_map), 64'(exp_valid));
         chk("R2 no error", 64'(err_status), 64'd0);
      end

      // R7 load every entry
      for (int e = 0; e < N; e++) load_check(e, 1, "R7");

      // R5 occupied entry
      set_area(8'h08);
      for (int b = 0; b < K; b++) beat(kw(3, b, 9));
      chk("R3 no early error", 64'(err_status), 64'd0);
      finish_dma();
      chk("R5 error", 64'(err_status), 64'b01);
      chk("R5 valid kept", 64'(valid_map), 64'(exp_valid));
      load_check(3, 1, "R5 key kept");

      // R9 sticky then clear
      repeat (3) tick();
      chk("R9 sticky", 64'(err_status), 64'b01);
      clr_err(2'b01);
      chk("R9 cleared", 64'(err_status), 64'b00);

      // R6 valid clear
      vclr_we = 1'b1; vclr_mask = 8'h08; tick();
      vclr_we = 1'b0; vclr_mask = '0;
      exp_valid[3] = 1'b0;
      chk("R6 cleared bit 3", 64'(valid_map), 64'(exp_valid));

      // R8 load of invalid entry
      ld_req = 1'b1; ld_idx = 3'd3; tick();
      ld_req = 1'b0;
      chk("R8 load error", 64'(err_status), 64'b10);
      for (int c = 0; c < 6; c++) begin
         chk("R8 no output", 64'({key_valid, ld_done, key_word}), 64'd0);
         tick();
      end

      // R3 partial write
      set_area(8'h08);
      beat(kw(3, 0, 5)); beat(kw(3, 1, 5));
      chk("R3 not before done", 64'(err_status), 64'b10);
      finish_dma();
      chk("R3 error", 64'(err_status), 64'b11);
      chk("R3 valid unchanged", 64'(valid_map), 64'(exp_valid));
      // R9 clear only one flag
      clr_err(2'b10);
      chk("R9 one flag cleared", 64'(err_status), 64'b01);
      // R9 set wins over clear in same cycle
      set_area(8'h08);
      beat(kw(3, 0, 5));
      dma_done = 1'b1; err_clr = 2'b01; tick();
      dma_done = 1'b0; err_clr = 2'b00;
      chk("R9 set wins", 64'(err_status), 64'b01);
      clr_err(2'b11);

      // R4 overflow beat
      set_area(8'h08);
      for (int b = 0; b < K + 1; b++) beat(kw(3, b, 6));
      finish_dma();
      chk("R4 overflow error", 64'(err_status), 64'b01);
      chk("R4 overflow valid", 64'(valid_map), 64'(exp_valid));
      clr_err(2'b01);
      // R4 stray beats with nothing armed
      beat(32'h1234_5678); beat(32'h9ABC_DEF0);
      finish_dma();
      chk("R4 stray error", 64'(err_status), 64'b01);
      clr_err(2'b01);
      // R4 non-one-hot selection
      set_area(8'h0C);
      chk("R4 bad select reads zero", 64'(area_sel), 64'd0);
      for (int b = 0; b < K; b++) beat(kw(3, b, 6));
      finish_dma();
      chk("R4 bad select error", 64'(err_status), 64'b01);
      chk("R4 bad select valid", 64'(valid_map), 64'(exp_valid));
      clr_err(2'b01);

      // R2 rewrite freed entry
      write_key(3, 7);
      exp_valid[3] = 1'b1;
      chk("R2 rewrite valid", 64'(valid_map), 64'(exp_valid));
      chk("R2 rewrite no error", 64'(err_status), 64'd0);
      load_check(3, 7, "R2 rewrite");

      // R11 request during a load is ignored
      ld_req = 1'b1; ld_idx = 3'd0; tick();
      ld_idx = 3'd5; tick();
      ld_req = 1'b0;
      chk("R11 word1 of first entry", 64'(key_word), 64'(kw(0, 1, 1)));
      tick();
      chk("R11 word2", 64'(key_word), 64'(kw(0, 2, 1)));
      tick();
      chk("R11 word3", 64'(key_word), 64'(kw(0, 3, 1)));
      tick();
      chk("R11 done", 64'(ld_done), 64'd1);
      tick();
      for (int c = 0; c < 4; c++) begin
         chk("R11 no second transfer", 64'({key_valid, ld_done}), 64'd0);
         tick();
      end
      chk("R11 no error", 64'(err_status), 64'd0);

      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule